// File: doc/BRIEF.md
# Bus Connection Gate for a Two-Wire Bus Buffer

This block decides when the backplane side and the card side of a two-wire (clock and data) bus buffer are joined. It takes the backplane clock and data levels and resynchronises them to its own clock. It looks for a stop condition on those lines and times how long both lines have stayed high, counting in microsecond ticks. When the enable input asks for a connection, the link is only closed at a point where the bus is safe: either a stop condition has just been seen, or the bus has been idle for a full window. The default window is 95 ticks. The link is opened at once, in the same cycle, when the enable input falls or when a stuck-bus recovery controller asserts its force-open input.

The ready output is active low and always shows the state of the link. When a forced disconnect ends, the gate does not reconnect right away. It waits again for a stop condition or an idle window, in the same way as after a rising enable.

Top module: `bus_join_gate`

## Requirements
- R1: After reset, `link_close_o` is 0 and `ready_n_o` is 1.
- R2: While `enable_i` is 0, `link_close_o` is 0 in the same cycle, with no wait for any clock edge.
- R3: With `enable_i` at 1 and the bus busy (no stop condition, no idle window), the link stays open.
- R4: A stop condition closes the link. A stop condition is a 0→1 change on the synchronised data line while the synchronised clock line is 1 in both the current and the previous sample.
- R5: If both lines are high and `IDLE_TICKS` tick pulses have been counted, the link closes. With fewer tick pulses it stays open.
- R6: A low level on either synchronised line clears the idle count, so the full `IDLE_TICKS` ticks must be counted again.
- R7: `ready_n_o` is the inverse of `link_close_o` in every cycle.
- R8: While `force_open_i` is 1, the link is open in the same cycle, whatever the value of `enable_i`.
- R9: After `force_open_i` returns to 0 with `enable_i` at 1, the link stays open until a new stop condition or a full idle window.
- R10: A rise of the data line while the clock line is low is not a stop condition and does not close the link.
- R11: The idle count advances only on cycles where `tick_us_i` is 1. With no ticks, an idle bus never closes the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Request to join the two sides |
| force_open_i | input | 1 | Override from the stuck-bus recovery controller; opens the link |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| scl_i | input | 1 | Backplane clock line level (asynchronous) |
| sda_i | input | 1 | Backplane data line level (asynchronous) |
| link_close_o | output | 1 | 1 = backplane and card sides connected |
| ready_n_o | output | 1 | Active-low ready, low while connected |

## Verification
The hardest case to reach is the edge of the idle window. The link must stay open after one tick fewer than the threshold and must close on the last tick. Both lines have to come high without forming a stop condition on the way. To do this, the stimulus raises data while the clock is still low, then raises the clock, and only then sends an exact number of tick pulses. A sweep repeats this over every tick count from zero to one past the threshold. A second case breaks the count with a single-cycle clock dip one tick before the threshold. This shows that the count starts over from zero.

// File: rtl/bus_join_pkg.sv
// Package: shared types for the bus connection gate.
// Assumes: imported by every module of the gate.
package bus_join_pkg;

    // Link controller states
    typedef enum logic [1:0] {
        LNK_OPEN   = 2'b00,  // disconnect requested or forced
        LNK_ARMED  = 2'b01,  // connect requested, waiting for a safe point
        LNK_JOINED = 2'b10   // sides connected
    } link_state_t;

endpackage

// File: rtl/bus_line_watch.sv
// Module: bus_line_watch
// Brings the asynchronous clock and data levels into the clk domain through
// SYNC_STAGES flops each, then flags a stop condition: data rising while the
// clock line is high in both the current and the previous sample.
// Assumes: SYNC_STAGES >= 1; the lines idle high (reset value 1).
module bus_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_prev;
    logic                   sda_prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First synchronizer stage: capture raw line levels
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q[0] <= 1'b1;
                        sda_q[0] <= 1'b1;
                    end else begin
                        scl_q[0] <= scl_i;
                        sda_q[0] <= sda_i;
                    end
                end
            end else begin : g_next
                // Later stage: pass the previous stage on
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q[g] <= 1'b1;
                        sda_q[g] <= 1'b1;
                    end else begin
                        scl_q[g] <= scl_q[g-1];
                        sda_q[g] <= sda_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_s_o = scl_q[SYNC_STAGES-1];
    assign sda_s_o = sda_q[SYNC_STAGES-1];

    // Keep one sample of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s_o;
            sda_prev <= sda_s_o;
        end
    end

    // Stop: data goes 0->1 while the clock stays high
    always_comb begin
        stop_o = scl_s_o && scl_prev && sda_s_o && !sda_prev;
    end

    // R10: a stop pulse lasts one cycle only
    p_stop_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

endmodule

// File: rtl/bus_idle_timer.sv
// Module: bus_idle_timer
// Counts microsecond ticks while both synchronised lines are high and raises
// idle_o when IDLE_TICKS ticks have been counted. The count saturates there.
// A low level on either line clears it.
// Assumes: IDLE_TICKS >= 1; tick_i is a single-cycle pulse.
module bus_idle_timer #(
    parameter int IDLE_TICKS = 95
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    input  logic tick_i,
    output logic idle_o
);

    localparam int                CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(IDLE_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             bus_high;

    assign bus_high = scl_s_i && sda_s_i;

    // Idle counter: clear on any low, advance on tick, saturate at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!bus_high) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_o = (cnt_q == LIMIT);

    // R6: a low line empties the count on the next edge
    p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_high |=> (cnt_q == '0));

    // R5: the count never passes the window
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R11: without a tick the count holds or clears, never grows
    p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));

endmodule

// File: rtl/bus_link_ctrl.sv
// Module: bus_link_ctrl
// State machine that holds the link open while the connection is not wanted,
// arms when it is wanted and joins on a stop condition or an idle window.
// Opening is combinational, so it takes effect in the same cycle.
// Assumes: stop_i is a one-cycle pulse; idle_i is a level.
module bus_link_ctrl
    import bus_join_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic stop_i,
    input  logic idle_i,
    output logic link_o
);

    link_state_t state_q;
    link_state_t state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!want_i) begin
            state_d = LNK_OPEN;
        end else begin
            unique case (state_q)
                LNK_OPEN:   state_d = LNK_ARMED;
                LNK_ARMED:  if (stop_i || idle_i) state_d = LNK_JOINED;
                LNK_JOINED: state_d = LNK_JOINED;
                default:    state_d = LNK_OPEN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LNK_OPEN;
        else        state_q <= state_d;
    end

    // Link output: joined and still wanted in this very cycle
    assign link_o = (state_q == LNK_JOINED) && want_i;

    // R4: armed with no safe point stays unjoined
    p_join_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_ARMED && !stop_i && !idle_i) |=> (state_q != LNK_JOINED));

    // R9: the joined state is only entered from the armed state
    p_join_from_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LNK_JOINED) |-> ($past(state_q) == LNK_ARMED));

endmodule

// File: rtl/bus_join_gate.sv
// Module: bus_join_gate (top)
// Joins the backplane and card sides of a two-wire bus buffer at a bus-safe
// point, and opens them at once on enable low or forced open. Drives an
// active-low ready that mirrors the link.
// Assumes: tick_us_i pulses for one clk cycle every microsecond.
module bus_join_gate #(
    parameter int IDLE_TICKS  = 95,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic force_open_i,
    input  logic tick_us_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic link_close_o,
    output logic ready_n_o
);

    logic scl_s;
    logic sda_s;
    logic stop_p;
    logic idle_l;
    logic want;

    assign want = enable_i && !force_open_i;

    bus_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .scl_s_o(scl_s),
        .sda_s_o(sda_s),
        .stop_o (stop_p)
    );

    bus_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s_i(scl_s),
        .sda_s_i(sda_s),
        .tick_i (tick_us_i),
        .idle_o (idle_l)
    );

    bus_link_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .want_i(want),
        .stop_i(stop_p),
        .idle_i(idle_l),
        .link_o(link_close_o)
    );

    assign ready_n_o = !link_close_o;

    // R2: a falling enable opens the link in that cycle
    p_open_on_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable_i) |-> !link_close_o);

    // R8: a forced open always wins over enable
    p_force_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_open_i |-> !link_close_o);

    // R4 / R5: a join starts only with a stop or an idle window
    p_join_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_close_o && !stop_p && !idle_l) |=> !link_close_o || !$past(want) || $past(link_close_o));

endmodule

// File: tb/bus_join_gate_tb.sv
module bus_join_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 6;
    localparam int SYNC       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic force_open_i = 1'b0;
    logic tick_us_i = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic link_close_o;
    logic ready_n_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_join_gate #(.IDLE_TICKS(IDLE), .SYNC_STAGES(SYNC)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .force_open_i(force_open_i),
        .tick_us_i   (tick_us_i),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .link_close_o(link_close_o),
        .ready_n_o   (ready_n_o)
    );

    // Compare the link and ready outputs, sampled 1 time unit after a negedge
    task automatic chk(input string req, input logic exp_link);
        #1;
        n_chk++;
        if (link_close_o !== exp_link) begin
            n_bad++;
            $display("FAIL %s link_close_o actual=%0b expected=%0b", req, link_close_o, exp_link);
        end
        n_chk++;
        if (ready_n_o !== !exp_link) begin
            n_bad++;
            $display("FAIL R7 (%s) ready_n_o actual=%0b expected=%0b", req, ready_n_o, !exp_link);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_us_i = 1'b1;
            cyc(1);
            tick_us_i = 1'b0;
            cyc(1);
        end
    endtask

    // Both lines high with no stop: data first, then clock
    task automatic bus_up_quiet();
        sda_i = 1'b0; scl_i = 1'b0;
        cyc(SYNC + 2);
        sda_i = 1'b1;
        cyc(SYNC + 2);
        scl_i = 1'b1;
        cyc(SYNC + 2);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        chk("R1", 1'b0);

        // Idle-window sweep over tick counts 0 .. IDLE+1
        for (int k = 0; k <= IDLE + 1; k++) begin
            enable_i = 1'b0;
            sda_i = 1'b0; scl_i = 1'b0;
            cyc(SYNC + 2);
            chk("R2", 1'b0);
            enable_i = 1'b1;
            bus_up_quiet();
            chk("R11", 1'b0);
            ticks(k);
            cyc(3);
            chk("R5", (k >= IDLE) ? 1'b1 : 1'b0);
        end

        // Enable low opens in the same cycle
        cyc(1);
        enable_i = 1'b0;
        chk("R2", 1'b0);

        // Busy bus: clock high, data low, no ticks -> stays open
        cyc(1);
        sda_i = 1'b0; scl_i = 1'b1;
        cyc(SYNC + 2);
        enable_i = 1'b1;
        cyc(SYNC + 6);
        chk("R3", 1'b0);
        ticks(IDLE + 2);
        chk("R3", 1'b0);

        // Stop condition: data rises while clock high
        sda_i = 1'b1;
        cyc(SYNC + 3);
        chk("R4", 1'b1);

        // Force open overrides enable at once
        force_open_i = 1'b1;
        chk("R8", 1'b0);
        sda_i = 1'b0;
        cyc(SYNC + 2);
        chk("R8", 1'b0);

        // Release force with a busy bus: must wait again
        force_open_i = 1'b0;
        cyc(SYNC + 6);
        chk("R9", 1'b0);
        sda_i = 1'b1;
        cyc(SYNC + 3);
        chk("R9", 1'b1);

        // Data rising with clock low is not a stop
        enable_i = 1'b0;
        cyc(1);
        sda_i = 1'b0; scl_i = 1'b0;
        cyc(SYNC + 2);
        enable_i = 1'b1;
        cyc(2);
        sda_i = 1'b1;
        cyc(SYNC + 4);
        chk("R10", 1'b0);
        scl_i = 1'b1;
        cyc(SYNC + 4);
        chk("R10", 1'b0);

        // A clock dip one tick short of the window restarts the count
        enable_i = 1'b0;
        cyc(1);
        enable_i = 1'b1;
        bus_up_quiet();
        ticks(IDLE - 1);
        scl_i = 1'b0;
        cyc(1);
        scl_i = 1'b1;
        cyc(SYNC + 3);
        ticks(IDLE - 1);
        cyc(3);
        chk("R6", 1'b0);
        ticks(1);
        cyc(3);
        chk("R6", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule